// File: doc/BRIEF.md
# Fault Lamp and Short Polling Controller

This block drives the fault-lamp enable and the field-gate poll enable of an alternator charging regulator. Four condition flags form the lamp request: undervoltage, overvoltage, a rotor frequency above the high-speed threshold, and a rotor frequency below the rotation-detect threshold. A load-dump-safe flag must also be high. Both outputs are gated by a run state derived from the ignition comparator.

One timebase is derived from the frame strobe. Once every poll period of `POLL_FRAMES` frames, it issues a single polling pulse of `PULSE_CLKS` clocks. The same pulse serves three purposes:

- While a lamp short is reported, the lamp is enabled only during this pulse.
- While a field source short is reported, the gate-poll enable is enabled only during this pulse.
- On an active, unshorted lamp, the pulse blanks the lamp so that an ignition input wired through the lamp goes high once per period.

An ignition off-delay, slightly longer than the poll period, holds the ignition-seen state between those blanking pulses. A start delay holds off full operation after ignition is first sensed. With ignition gone and the rotor stopped, the block drops to standby and clears its timebase.

Top module: `fault_lamp_ctrl`

## Requirements
- R1: The lamp request is (uv_i AND hf_i) OR ov_i OR lf_i. When the block is running, ld_safe_i=1, lamp_short_i=0 and no polling pulse is active, lamp_en_o equals the request in the same cycle.
- R2: ld_safe_i=0 forces lamp_en_o=0 and gate_poll_o=0 in the same cycle, whatever the other inputs are.
- R3: While lamp_short_i=1, lamp_en_o equals the lamp request ANDed with the polling pulse, and is 0 outside the pulse.
- R4: While src_short_i=1, gate_poll_o is 1 only during the polling pulse. While src_short_i=0, gate_poll_o is 1 whenever the block is running and ld_safe_i=1.
- R5: When a short input drops to 0, the affected output returns to its normal value in that same cycle, without waiting for a poll period.
- R6: With no lamp short, lamp_en_o is forced to 0 for the whole polling pulse (blanking), so a lit lamp is on for (period − PULSE_CLKS) of every period.
- R7: The timebase counts frame strobes modulo POLL_FRAMES, starting from 0 when the block leaves standby. A strobe sampled while the count is 0 starts the polling pulse on the next clock, and the pulse lasts exactly PULSE_CLKS clocks.
- R8: The ignition-seen state is reloaded to OFF_DLY_CLKS on every clock where ign_i=1, and expires OFF_DLY_CLKS clocks after the last such clock. This keeps the block running across lamp-wired ignition that pulses once per period.
- R9: A clock edge in standby that samples ign_i=1 enters the start-up state. active_o rises START_CLKS clock edges later, provided standby was not re-entered in between. During start-up, the outputs follow R1 to R6 but active_o stays 0.
- R10: When the ignition-seen state has expired and lf_i=1, the block enters standby on the next edge. In standby, active_o, lamp_en_o and gate_poll_o are 0, and the timebase is cleared. During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | One-clock strobe at each PWM frame start |
| uv_i | input | 1 | Undervoltage flag |
| ov_i | input | 1 | Overvoltage flag |
| hf_i | input | 1 | Rotor frequency above high-speed threshold |
| lf_i | input | 1 | Rotor frequency below rotation-detect threshold |
| ld_safe_i | input | 1 | 1 = no load dump; 0 forces outputs off |
| lamp_short_i | input | 1 | Lamp drain short comparator |
| src_short_i | input | 1 | Field source short comparator |
| ign_i | input | 1 | Ignition comparator |
| lamp_en_o | output | 1 | Lamp driver enable |
| gate_poll_o | output | 1 | Field gate poll enable |
| active_o | output | 1 | 1 = full operation, 0 = standby or start-up |

## Verification
Lamp and gate-poll enables respond in the same cycle to the flags, the short bits and the load-dump flag. They respond one clock after a frame strobe to the timebase, and one clock after a state change to the run state. The bench therefore drives all inputs at the falling edge and compares shortly after it, before the next rising edge. active_o changes one clock after the edge on which the sequencer decides. For start-up, that is START_CLKS edges after the edge that first samples ignition. For the off-delay, it is one edge after the counter expires with lf_i high. The model in the bench advances its own counters after each rising edge using the inputs held across that edge, so every comparison lands on the cycle in which the response is due.

// File: rtl/fault_lamp_pkg.sv
package fault_lamp_pkg;
  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_STARTUP = 2'd1,
    ST_ACTIVE  = 2'd2
  } run_state_e;
endpackage

// File: rtl/poll_timebase.sv
module poll_timebase #(
  parameter int POLL_FRAMES = 4,
  parameter int PULSE_CLKS  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic frame_i,
  output logic pulse_o
);
  localparam int FW = (POLL_FRAMES > 1) ? $clog2(POLL_FRAMES) : 1;
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(POLL_FRAMES - 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CLKS);

  logic [FW-1:0] frame_cnt_q;
  logic [PW-1:0] pulse_cnt_q;
  logic          period_start;

  assign period_start = frame_i && (frame_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_cnt_q <= '0;
      pulse_cnt_q <= '0;
    end else if (clear_i) begin
      frame_cnt_q <= '0;
      pulse_cnt_q <= '0;
    end else begin
      if (frame_i)
        frame_cnt_q <= (frame_cnt_q == FRAME_LAST) ? '0 : frame_cnt_q + 1'b1;
      if (period_start)
        pulse_cnt_q <= PULSE_LOAD;
      else if (pulse_cnt_q != '0)
        pulse_cnt_q <= pulse_cnt_q - 1'b1;
    end
  end

  assign pulse_o = (pulse_cnt_q != '0);
endmodule

// File: rtl/ign_sequencer.sv
module ign_sequencer
  import fault_lamp_pkg::*;
#(
  parameter int OFF_DLY_CLKS = 1030,
  parameter int START_CLKS   = 50500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ign_i,
  input  logic       lf_i,
  output run_state_e state_o,
  output logic       ign_seen_o
);
  localparam int OW = $clog2(OFF_DLY_CLKS + 1);
  localparam int SW = (START_CLKS > 1) ? $clog2(START_CLKS) : 1;
  localparam logic [OW-1:0] OFF_LOAD   = OW'(OFF_DLY_CLKS);
  localparam logic [SW-1:0] START_LAST = SW'(START_CLKS - 1);

  logic [OW-1:0] off_cnt_q;
  logic [SW-1:0] start_cnt_q;
  run_state_e    state_q;
  logic          sleep_req;

  assign ign_seen_o = (off_cnt_q != '0);
  assign sleep_req  = !ign_seen_o && lf_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          off_cnt_q <= '0;
    else if (ign_i)       off_cnt_q <= OFF_LOAD;
    else if (ign_seen_o)  off_cnt_q <= off_cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_STANDBY;
      start_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_STANDBY: if (ign_i) begin
          state_q     <= ST_STARTUP;
          start_cnt_q <= '0;
        end
        ST_STARTUP: begin
          if (sleep_req)                    state_q <= ST_STANDBY;
          else if (start_cnt_q == START_LAST) state_q <= ST_ACTIVE;
          else                              start_cnt_q <= start_cnt_q + 1'b1;
        end
        ST_ACTIVE: if (sleep_req) state_q <= ST_STANDBY;
        default: state_q <= ST_STANDBY;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lamp_gate_mux.sv
module lamp_gate_mux (
  input  logic run_i,
  input  logic pulse_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic hf_i,
  input  logic lf_i,
  input  logic ld_safe_i,
  input  logic lamp_short_i,
  input  logic src_short_i,
  output logic lamp_en_o,
  output logic gate_poll_o
);
  logic lamp_req, enable, lamp_window, gate_window;

  always_comb begin
    lamp_req    = (uv_i && hf_i) || ov_i || lf_i;
    enable      = run_i && ld_safe_i;
    // short: retry only inside pulse; healthy lamp: blank inside pulse
    lamp_window = lamp_short_i ? pulse_i : !pulse_i;
    gate_window = src_short_i ? pulse_i : 1'b1;
    lamp_en_o   = enable && lamp_req && lamp_window;
    gate_poll_o = enable && gate_window;
  end
endmodule

// File: rtl/fault_lamp_ctrl.sv
module fault_lamp_ctrl
  import fault_lamp_pkg::*;
#(
  parameter int POLL_FRAMES  = 4,
  parameter int PULSE_CLKS   = 16,
  parameter int OFF_DLY_CLKS = 1030,
  parameter int START_CLKS   = 50500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic hf_i,
  input  logic lf_i,
  input  logic ld_safe_i,
  input  logic lamp_short_i,
  input  logic src_short_i,
  input  logic ign_i,
  output logic lamp_en_o,
  output logic gate_poll_o,
  output logic active_o
);
  run_state_e state;
  logic       ign_seen;
  logic       run;
  logic       pulse;

  ign_sequencer #(
    .OFF_DLY_CLKS(OFF_DLY_CLKS),
    .START_CLKS  (START_CLKS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ign_i     (ign_i),
    .lf_i      (lf_i),
    .state_o   (state),
    .ign_seen_o(ign_seen)
  );

  assign run = (state != ST_STANDBY);

  poll_timebase #(
    .POLL_FRAMES(POLL_FRAMES),
    .PULSE_CLKS (PULSE_CLKS)
  ) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!run),
    .frame_i(frame_i),
    .pulse_o(pulse)
  );

  lamp_gate_mux u_mux (
    .run_i       (run),
    .pulse_i     (pulse),
    .uv_i        (uv_i),
    .ov_i        (ov_i),
    .hf_i        (hf_i),
    .lf_i        (lf_i),
    .ld_safe_i   (ld_safe_i),
    .lamp_short_i(lamp_short_i),
    .src_short_i (src_short_i),
    .lamp_en_o   (lamp_en_o),
    .gate_poll_o (gate_poll_o)
  );

  assign active_o = (state == ST_ACTIVE);
endmodule

// File: rtl/fault_lamp_ctrl_chk.sv
module fault_lamp_ctrl_chk #(
  parameter int PULSE_CLKS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ld_safe_i,
  input logic lamp_short_i,
  input logic src_short_i,
  input logic lamp_en_o,
  input logic gate_poll_o,
  input logic active_o,
  input logic run,
  input logic pulse,
  input logic ign_seen,
  input logic lf_i
);
  localparam int LW = $clog2(PULSE_CLKS + 2);
  logic [LW-1:0] pulse_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pulse_len_q <= '0;
    else if (!pulse)              pulse_len_q <= '0;
    else if (pulse_len_q <= LW'(PULSE_CLKS)) pulse_len_q <= pulse_len_q + 1'b1;
  end

  // R2
  ld_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_safe_i |-> (!lamp_en_o && !gate_poll_o));

  // R3
  lamp_short_in_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_short_i && lamp_en_o) |-> pulse);

  // R6
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lamp_short_i && pulse) |-> !lamp_en_o);

  // R4
  gate_healthy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ld_safe_i && !src_short_i) |-> gate_poll_o);

  // R7
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_len_q <= LW'(PULSE_CLKS));

  // R9
  no_direct_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(run));

  // R10
  standby_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !ign_seen && lf_i) |=> !run);

  // R10
  standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!lamp_en_o && !gate_poll_o && !active_o));
endmodule

bind fault_lamp_ctrl fault_lamp_ctrl_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_safe_i   (ld_safe_i),
  .lamp_short_i(lamp_short_i),
  .src_short_i (src_short_i),
  .lamp_en_o   (lamp_en_o),
  .gate_poll_o (gate_poll_o),
  .active_o    (active_o),
  .run         (run),
  .pulse       (pulse),
  .ign_seen    (ign_seen),
  .lf_i        (lf_i)
);

// File: tb/fault_lamp_ctrl_test.sv
module fault_lamp_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PF    = 4;
  localparam int PC    = 16;
  localparam int FRAME = 64;
  localparam int OFFD  = 272;
  localparam int STRT  = 100;

  logic clk = 0, rst_ni = 0;
  logic frame_i = 0, uv_i = 0, ov_i = 0, hf_i = 0, lf_i = 0;
  logic ld_safe_i = 1, lamp_short_i = 0, src_short_i = 0, ign_i = 0;
  logic lamp_en_o, gate_poll_o, active_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_lamp_ctrl #(.POLL_FRAMES(PF), .PULSE_CLKS(PC),
                    .OFF_DLY_CLKS(OFFD), .START_CLKS(STRT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .uv_i(uv_i), .ov_i(ov_i),
    .hf_i(hf_i), .lf_i(lf_i), .ld_safe_i(ld_safe_i), .lamp_short_i(lamp_short_i),
    .src_short_i(src_short_i), .ign_i(ign_i), .lamp_en_o(lamp_en_o),
    .gate_poll_o(gate_poll_o), .active_o(active_o));

  int checks = 0, errors = 0, cyc = 0;
  // next-cycle stimulus, applied at the falling edge
  logic n_uv = 0, n_ov = 0, n_hf = 0, n_lf = 0, n_ld = 1, n_ls = 0, n_ss = 0, n_ign = 0;
  logic rand_frame = 0, n_rframe = 0;
  // reference model
  int m_state = 0, m_off = 0, m_start = 0, m_fcnt = 0, m_pulse = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned nxt();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check1(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", tag, name, cyc, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic req, run, p, e_lamp, e_gate, e_act, st;
    @(negedge clk);
    uv_i = n_uv; ov_i = n_ov; hf_i = n_hf; lf_i = n_lf; ld_safe_i = n_ld;
    lamp_short_i = n_ls; src_short_i = n_ss; ign_i = n_ign;
    frame_i = rand_frame ? n_rframe : ((cyc % FRAME) == 0);
    #1;
    req    = (uv_i && hf_i) || ov_i || lf_i;
    run    = (m_state != 0);
    p      = (m_pulse != 0);
    e_lamp = run && ld_safe_i && req && (lamp_short_i ? p : !p);
    e_gate = run && ld_safe_i && (src_short_i ? p : 1'b1);
    e_act  = (m_state == 2);
    check1(tag, "lamp_en_o", lamp_en_o, e_lamp);
    check1(tag, "gate_poll_o", gate_poll_o, e_gate);
    check1(tag, "active_o", active_o, e_act);
    @(posedge clk);
    begin
      automatic int pst = m_state;
      automatic logic sleep = (m_off == 0) && lf_i;
      if (ign_i) m_off = OFFD; else if (m_off > 0) m_off--;
      case (pst)
        0: if (ign_i) begin m_state = 1; m_start = 0; end
        1: if (sleep) m_state = 0; else if (m_start == STRT-1) m_state = 2; else m_start++;
        default: if (sleep) m_state = 0;
      endcase
      if (pst == 0) begin m_fcnt = 0; m_pulse = 0; end
      else begin
        st = frame_i && (m_fcnt == 0);
        if (frame_i) m_fcnt = (m_fcnt == PF-1) ? 0 : m_fcnt + 1;
        if (st) m_pulse = PC; else if (m_pulse > 0) m_pulse--;
      end
    end
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check1("R10", "lamp_en_o", lamp_en_o, 1'b0);
    check1("R10", "gate_poll_o", gate_poll_o, 1'b0);
    check1("R10", "active_o", active_o, 1'b0);
    rst_ni = 1;
    // R9 start-up with engine stopped (lamp lit by low-frequency flag)
    n_ign = 1; n_lf = 1;
    repeat (STRT + 20) step("R9");
    // R1 random flags, no shorts
    n_lf = 0;
    for (int i = 0; i < 600; i++) begin
      int unsigned r = nxt();
      n_uv = r[0]; n_ov = r[1] & r[2]; n_hf = r[3]; n_lf = r[4] & r[5] & r[6];
      step("R1");
    end
    // R6 lit lamp blanked each pulse
    n_uv = 0; n_hf = 0; n_lf = 0; n_ov = 1;
    repeat (300) step("R6");
    // R3 lamp short retry
    n_ls = 1;
    repeat (600) step("R3");
    // R4 source short retry
    n_ls = 0; n_ss = 1;
    repeat (600) step("R4");
    // R5 shorts clearing and returning
    for (int i = 0; i < 600; i++) begin
      n_ls = ((i / 37) % 2) == 1; n_ss = ((i / 23) % 2) == 0;
      step("R5");
    end
    // R2 load-dump flag toggling
    n_ls = 0; n_ss = 0;
    for (int i = 0; i < 400; i++) begin
      int unsigned r = nxt();
      n_ld = r[1] | r[2]; n_ls = r[7] & r[8]; n_ss = r[9] & r[10];
      step("R2");
    end
    // R7 irregular frame strobes
    n_ld = 1; n_ls = 1; n_ss = 0; rand_frame = 1;
    for (int i = 0; i < 800; i++) begin
      int unsigned r = nxt();
      n_rframe = (r[4:0] == 5'd0);
      step("R7");
    end
    rand_frame = 0; n_ls = 0;
    // R8 ignition sensed only while lamp blanked
    n_ov = 0; n_lf = 1;
    for (int i = 0; i < 1500; i++) begin
      n_ign = (m_pulse != 0);
      step("R8");
    end
    // R10 ignition lost with rotor stopped
    n_ign = 0;
    repeat (600) step("R10");
    n_ign = 1;
    repeat (3) step("R10");
    n_ign = 0; n_lf = 0;
    repeat (200) step("R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule